// File: doc/BRIEF.md
# Key-Unlocked Flash Program Controller

This block sequences word-program and page-erase operations on an on-chip flash array, which a behavioural model stands in for. Software reaches it over a simple register bus with one write strobe, one read strobe, a byte address and 32-bit write and read data. Four registers are visible: a control/status register (with separate set and clear alias addresses), a key register, a target address register and a write data register. The array can also be read through an address window.

Nothing is launched by accident. Software first selects the operation and sets write enable. It then writes three exact values to the key register in a fixed order, and only then sets the start bit. The start bit stays high as a busy flag for a parameterised number of cycles and clears itself when the work is done. Two sticky flags report a refused start and a supply dip during the operation. Software clears both flags by running the no-op operation through the same unlock-and-start flow.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the control register reads 0, the target and data registers read 0, and every array word reads 0xFFFFFFFF. Array words are read at byte address 0x8000 + 4*(page*PAGE_WORDS + word).
- R2: The block is unlocked only by three key writes (offset 0x10) in this order: 0x00000000, 0xAA996655, 0x556699AA. Any other key write returns the tracker to its start. A start attempt without the unlock sets the write/lock error (control bit 13) and leaves the array unchanged.
- R3: Any write to the control register, at 0x00, 0x04 or 0x08, uses up the unlock, even a write that changes nothing.
- R4: A start attempt while write enable (control bit 14) is clear has no effect. The start bit (bit 15) reads 0 afterwards and no error flag is set.
- R5: Page erase (op field bits 3:0 = 4) sets every word of the target page to 0xFFFFFFFF and leaves all other pages untouched. Bit 15 reads 1 for exactly ERASE_CYC cycles and then clears.
- R6: Word program (op = 1) ANDs the write data register (0x30) into the word addressed by the target register (0x20). In that register, bits [5:2] select the word and bits [11:6] select the page. Bit 15 reads 1 for exactly PROG_CYC cycles.
- R7: A write to 0x08 sets, and a write to 0x04 clears, exactly those control bits that are 1 in the write data. A write to 0x00 replaces the writable fields.
- R8: A start aimed at a page whose page_lock bit is 1 sets bit 13 and does not change the array.
- R9: If low_volt is high in any cycle of a running operation, bit 12 is set when the operation ends and the array is left unchanged.
- R10: A no-op (op = 0) started after a valid unlock with write enable set clears bits 13 and 12. The start bit reads 0 one cycle later.
- R11: While busy, start requests, op field changes and writes to the target and data registers are ignored. Write enable stays writable. Bus writes never set bits 13 or 12 directly.
- R12: A start with an op code other than 0, 1 or 4 sets bit 13 and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_addr | input | ADDR_W | Byte address; top bit selects the array window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| page_lock | input | PAGES | One lock bit per page |
| low_volt | input | 1 | Supply-dip indication sampled during an operation |

## Verification
The collision that matters most is an operation finishing in the same cycle that software writes the control register. The bench times a clear-alias write of write enable to land exactly on the edge where a word program completes. It then expects the new word in the array, busy low and write enable low, so neither event may swallow the other. The second overlap is a start request, or target and data writes, arriving while an erase is running. These must be dropped, and the erase must finish on the page it latched. A behavioural model predicts the read data on every clock, and both cases are judged against it.

// File: rtl/flash_ctrl_pkg.sv
// Shared constants for the flash program controller.
// Assumes a 32-bit register bus and byte offsets below 0x40.
package flash_ctrl_pkg;
    localparam int DW = 32;

    // Register byte offsets.
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CLR  = 8'h04;
    localparam logic [7:0] OFS_SET  = 8'h08;
    localparam logic [7:0] OFS_KEY  = 8'h10;
    localparam logic [7:0] OFS_TGT  = 8'h20;
    localparam logic [7:0] OFS_DAT  = 8'h30;

    // Control bit positions.
    localparam int B_START = 15;
    localparam int B_WREN  = 14;
    localparam int B_WERR  = 13;
    localparam int B_LVERR = 12;

    // Unlock key sequence.
    localparam logic [DW-1:0] KEY_1 = 32'h0000_0000;
    localparam logic [DW-1:0] KEY_2 = 32'hAA99_6655;
    localparam logic [DW-1:0] KEY_3 = 32'h5566_99AA;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_WORD = 4'd1,
        OP_PAGE = 4'd4
    } nvm_op_e;
endpackage

// File: rtl/flash_key_unlock.sv
// Tracks the three-write key sequence.
// Assumes at most one bus write per cycle; consume wins over a key write.
module flash_key_unlock
    import flash_ctrl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    input  logic          consume,
    output logic          unlocked
);
    logic [1:0] stage_q;

    // Advance on the expected key value, fall back on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 2'd0;
        end else if (consume) begin
            stage_q <= 2'd0;
        end else if (key_wr) begin
            case (stage_q)
                2'd0:    stage_q <= (key_data == KEY_1) ? 2'd1 : 2'd0;
                2'd1:    stage_q <= (key_data == KEY_2) ? 2'd2 : 2'd0;
                2'd2:    stage_q <= (key_data == KEY_3) ? 2'd3 : 2'd0;
                default: stage_q <= 2'd0;
            endcase
        end
    end

    assign unlocked = (stage_q == 2'd3);
endmodule

// File: rtl/flash_op_seq.sv
// Times one operation and watches the supply while it runs.
// Assumes launch is only raised while not busy.
module flash_op_seq #(
    parameter int ERASE_CYC = 24,
    parameter int PROG_CYC  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic launch_erase,
    input  logic low_volt,
    output logic busy,
    output logic finish,
    output logic lv_fault
);
    localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC);
    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic             lv_q;

    assign busy     = (cnt_q != '0);
    assign finish   = (cnt_q == CNT_W'(1));
    assign lv_fault = lv_q | low_volt;

    // Load the duration on launch, count down and gather supply dips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lv_q  <= 1'b0;
        end else if (launch) begin
            cnt_q <= launch_erase ? ERASE_LD : PROG_LD;
            lv_q  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - CNT_W'(1);
            lv_q  <= lv_fault;
        end
    end
endmodule

// File: rtl/flash_array_model.sv
// Behavioural flash array: erase writes ones, program ANDs data in.
// Assumes PAGES and PAGE_WORDS are powers of two; contents reset to erased.
module flash_array_model
    import flash_ctrl_pkg::*;
#(
    parameter int PAGES      = 64,
    parameter int PAGE_WORDS = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     commit,
    input  logic                                     erase,
    input  logic [$clog2(PAGES)-1:0]                 page,
    input  logic [$clog2(PAGE_WORDS)-1:0]            word,
    input  logic [DW-1:0]                            data,
    input  logic [$clog2(PAGES)+$clog2(PAGE_WORDS)-1:0] rd_idx,
    output logic [DW-1:0]                            rd_data
);
    localparam int PG_W  = $clog2(PAGES);
    localparam int WD_W  = $clog2(PAGE_WORDS);
    localparam int DEPTH = PAGES * PAGE_WORDS;

    logic [DW-1:0] rd_vec [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [PG_W-1:0] MY_PG = PG_W'(g / PAGE_WORDS);
        localparam logic [WD_W-1:0] MY_WD = WD_W'(g % PAGE_WORDS);
        logic [DW-1:0] cell_q;

        // Update this word when its page or word is the commit target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else if (commit && page == MY_PG) begin
                if (erase)
                    cell_q <= '1;
                else if (word == MY_WD)
                    cell_q <= cell_q & data;
            end
        end

        assign rd_vec[g] = cell_q;
    end

    assign rd_data = rd_vec[rd_idx];
endmodule

// File: rtl/flash_prog_ctrl.sv
// Register front end of the key-unlocked flash program controller.
// Assumes one bus access per cycle; reads are combinational.
module flash_prog_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int PAGES      = 64,
    parameter int PAGE_WORDS = 16,
    parameter int ADDR_W     = 16,
    parameter int ERASE_CYC  = 24,
    parameter int PROG_CYC   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PAGES-1:0]  page_lock,
    input  logic              low_volt
);
    localparam int PG_W  = $clog2(PAGES);
    localparam int WD_W  = $clog2(PAGE_WORDS);
    localparam int IDX_W = PG_W + WD_W;

    logic          wren_q, err_wr_q, err_lv_q;
    logic [3:0]    op_q;
    logic [DW-1:0] tgt_q, dat_q, arr_rd;
    logic          busy, finish, lv_fault, key_ok;

    wire wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    wire wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
    wire wr_set  = bus_wr && (bus_addr == ADDR_W'(OFS_SET));
    wire wr_key  = bus_wr && (bus_addr == ADDR_W'(OFS_KEY));
    wire wr_tgt  = bus_wr && (bus_addr == ADDR_W'(OFS_TGT));
    wire wr_dat  = bus_wr && (bus_addr == ADDR_W'(OFS_DAT));
    wire ctrl_wr_any = wr_ctrl | wr_clr | wr_set;

    // Merge a field with write data under plain, set or clear write.
    function automatic logic [3:0] merge(input logic [3:0] cur, input logic [3:0] w,
                                         input logic pl, input logic st, input logic cl);
        if (pl)      return w;
        else if (st) return cur | w;
        else if (cl) return cur & ~w;
        else         return cur;
    endfunction

    logic [3:0] nxt_op, nxt_start, nxt_wren;
    logic [PG_W-1:0] page_sel;
    logic [WD_W-1:0] word_sel;

    // Next values of the writable control fields.
    always_comb begin
        nxt_op    = merge(op_q, bus_wdata[3:0], wr_ctrl, wr_set, wr_clr);
        nxt_start = merge({3'b0, busy}, {3'b0, bus_wdata[B_START]}, wr_ctrl, wr_set, wr_clr);
        nxt_wren  = merge({3'b0, wren_q}, {3'b0, bus_wdata[B_WREN]}, wr_ctrl, wr_set, wr_clr);
    end

    assign page_sel = tgt_q[2+WD_W +: PG_W];
    assign word_sel = tgt_q[2 +: WD_W];

    wire start_req = ctrl_wr_any && nxt_start[0] && nxt_wren[0] && !busy;
    wire op_nop    = (nxt_op == OP_NOP);
    wire op_legal  = (nxt_op == OP_WORD) || (nxt_op == OP_PAGE);
    wire launch    = start_req && key_ok && op_legal && !page_lock[page_sel];
    wire commit    = finish && !lv_fault;

    // Writable control fields, target and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wren_q <= 1'b0;
            op_q   <= '0;
            tgt_q  <= '0;
            dat_q  <= '0;
        end else begin
            if (ctrl_wr_any)          wren_q <= nxt_wren[0];
            if (ctrl_wr_any && !busy) op_q   <= nxt_op;
            if (wr_tgt && !busy)      tgt_q  <= bus_wdata;
            if (wr_dat && !busy)      dat_q  <= bus_wdata;
        end
    end

    // Sticky error flags: set by refused starts and supply dips, cleared by no-op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_wr_q <= 1'b0;
            err_lv_q <= 1'b0;
        end else if (start_req) begin
            if (!key_ok)
                err_wr_q <= 1'b1;
            else if (op_nop) begin
                err_wr_q <= 1'b0;
                err_lv_q <= 1'b0;
            end else if (!op_legal || page_lock[page_sel])
                err_wr_q <= 1'b1;
        end else if (finish && lv_fault) begin
            err_lv_q <= 1'b1;
        end
    end

    flash_key_unlock u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_key),
        .key_data (bus_wdata),
        .consume  (ctrl_wr_any),
        .unlocked (key_ok)
    );

    flash_op_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_erase (nxt_op == OP_PAGE),
        .low_volt     (low_volt),
        .busy         (busy),
        .finish       (finish),
        .lv_fault     (lv_fault)
    );

    flash_array_model #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .erase   (op_q == OP_PAGE),
        .page    (page_sel),
        .word    (word_sel),
        .data    (dat_q),
        .rd_idx  (bus_addr[2 +: IDX_W]),
        .rd_data (arr_rd)
    );

    // Read data mux over registers and array window.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr[ADDR_W-1]) begin
                bus_rdata = arr_rd;
            end else begin
                case (bus_addr)
                    ADDR_W'(OFS_CTRL), ADDR_W'(OFS_CLR), ADDR_W'(OFS_SET):
                        bus_rdata = {16'h0, busy, wren_q, err_wr_q, err_lv_q, 8'h0, op_q};
                    ADDR_W'(OFS_TGT): bus_rdata = tgt_q;
                    ADDR_W'(OFS_DAT): bus_rdata = dat_q;
                    default:          bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_ctrl_chk.sv
// Protocol checks for flash_prog_ctrl, attached by bind.
// Assumes the reset is synchronous and active low.
module flash_ctrl_chk #(
    parameter int ERASE_CYC = 24,
    parameter int PROG_CYC  = 6
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic key_ok,
    input logic ctrl_wr,
    input logic bus_wr,
    input logic err_wr,
    input logic err_lv
);
    int run_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R2
    launch_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(key_ok));

    // R3
    key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !key_ok);

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == ERASE_CYC || run_len == PROG_CYC));

    // R11
    err_write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_wr) |-> $past(bus_wr));

    // R9
    err_lv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_lv) |-> $past(busy));
endmodule

bind flash_prog_ctrl flash_ctrl_chk #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .key_ok  (key_ok),
    .ctrl_wr (ctrl_wr_any),
    .bus_wr  (bus_wr),
    .err_wr  (err_wr_q),
    .err_lv  (err_lv_q)
);

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;
    localparam int ERASE = 24;
    localparam int PROG  = 6;
    localparam logic [15:0] ARR = 16'h8000;

    logic        clk = 0, rst_n = 0;
    logic        b_wr = 0, b_rd = 0;
    logic [15:0] b_addr = 0;
    logic [31:0] b_wdata = 0;
    logic [31:0] rdata;
    logic [63:0] lock = 0;
    logic        lowv = 0;

    int    n_cmp = 0, n_bad = 0;
    bit    cmp_on = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    flash_prog_ctrl #(.PAGES(64), .PAGE_WORDS(16), .ADDR_W(16),
                      .ERASE_CYC(ERASE), .PROG_CYC(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .page_lock(lock), .low_volt(lowv));

    // Reference model state
    int          m_cnt, m_stage;
    bit          m_wren, m_werr, m_lverr, m_lvseen;
    bit   [3:0]  m_op;
    bit   [31:0] m_tgt, m_dat;
    bit   [31:0] m_mem [1024];

    always @(posedge clk) begin
        bit was_busy, lv, st;
        bit [31:0] cur, nxt;
        if (!rst_n) begin
            m_cnt = 0; m_stage = 0; m_wren = 0; m_werr = 0; m_lverr = 0;
            m_lvseen = 0; m_op = 0; m_tgt = 0; m_dat = 0;
            foreach (m_mem[i]) m_mem[i] = 32'hFFFF_FFFF;
        end else begin
            was_busy = (m_cnt > 0);
            if (was_busy) begin
                lv = m_lvseen | lowv;
                if (m_cnt == 1 && !lv) begin
                    if (m_op == 4)
                        for (int w = 0; w < 16; w++) m_mem[{m_tgt[11:6], 4'(w)}] = 32'hFFFF_FFFF;
                    else
                        m_mem[m_tgt[11:2]] = m_mem[m_tgt[11:2]] & m_dat;
                end
                if (m_cnt == 1 && lv) m_lverr = 1;
                m_lvseen = lv;
                m_cnt--;
            end
            if (b_wr) begin
                if (b_addr == 16'h0 || b_addr == 16'h4 || b_addr == 16'h8) begin
                    cur = {16'h0, was_busy, m_wren, 10'h0, m_op};
                    if (b_addr == 16'h0)      nxt = b_wdata;
                    else if (b_addr == 16'h8) nxt = cur | b_wdata;
                    else                      nxt = cur & ~b_wdata;
                    st = nxt[15] && nxt[14] && !was_busy;
                    m_wren = nxt[14];
                    if (!was_busy) m_op = nxt[3:0];
                    if (st) begin
                        if (m_stage != 3) m_werr = 1;
                        else if (m_op == 0) begin m_werr = 0; m_lverr = 0; end
                        else if ((m_op != 1 && m_op != 4) || lock[m_tgt[11:6]]) m_werr = 1;
                        else begin m_cnt = (m_op == 4) ? ERASE : PROG; m_lvseen = 0; end
                    end
                    m_stage = 0;
                end else if (b_addr == 16'h10) begin
                    case (m_stage)
                        0: m_stage = (b_wdata == 32'h0) ? 1 : 0;
                        1: m_stage = (b_wdata == 32'hAA996655) ? 2 : 0;
                        2: m_stage = (b_wdata == 32'h556699AA) ? 3 : 0;
                        default: m_stage = 0;
                    endcase
                end else if (b_addr == 16'h20) begin
                    if (!was_busy) m_tgt = b_wdata;
                end else if (b_addr == 16'h30) begin
                    if (!was_busy) m_dat = b_wdata;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        if (!b_rd) return 32'h0;
        if (b_addr[15]) return m_mem[b_addr[11:2]];
        case (b_addr)
            16'h0, 16'h4, 16'h8: return {16'h0, m_cnt > 0, m_wren, m_werr, m_lverr, 8'h0, m_op};
            16'h20: return m_tgt;
            16'h30: return m_dat;
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle: compare the previous cycle's read, then drive.
    task automatic step(input bit wr, input bit rd, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        if (cmp_on) begin
            n_cmp++;
            if (rdata !== exp_rd()) begin
                n_bad++;
                $display("FAIL %s: cycle compare addr %h got %h exp %h", cur_req, b_addr, rdata, exp_rd());
            end
        end
        b_wr = wr; b_rd = rd; b_addr = a; b_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 16'h0, 32'h0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        step(1, 0, a, d);
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string req);
        step(0, 1, a, 32'h0);
        #1;
        n_cmp++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s: read %h got %h exp %h", req, a, rdata, e);
        end
    endtask

    task automatic unlock();
        wr(16'h10, 32'h0); wr(16'h10, 32'hAA996655); wr(16'h10, 32'h556699AA);
    endtask

    task automatic nop_clear();
        wr(16'h0, 32'h4000); unlock(); wr(16'h8, 32'h8000);
    endtask

    function automatic logic [31:0] pa(input int p, input int w);
        return 32'((p << 6) | (w << 2));
    endfunction

    task automatic run_op(input int p, input int w, input logic [31:0] d, input logic [3:0] op);
        wr(16'h20, pa(p, w)); wr(16'h30, d); wr(16'h0, {16'h0, 16'h4000 | 16'(op)});
        unlock(); wr(16'h8, 32'h8000);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        cmp_on = 1;
        cur_req = "R1";
        rd(16'h0, 32'h0, "R1"); rd(16'h20, 32'h0, "R1"); rd(16'h30, 32'h0, "R1");
        rd(ARR | 16'(pa(3, 5)), 32'hFFFF_FFFF, "R1");

        cur_req = "R6";
        run_op(2, 3, 32'h0F0F_1234, 4'd1);
        rd(16'h0, 32'h0000_C001, "R6");
        idle(PROG + 1);
        rd(16'h0, 32'h0000_4001, "R6");
        rd(ARR | 16'(pa(2, 3)), 32'h0F0F_1234, "R6");
        run_op(2, 3, 32'hFF00_FFFF, 4'd1);
        idle(PROG + 1);
        rd(ARR | 16'(pa(2, 3)), 32'h0F00_1234, "R6");

        cur_req = "R5";
        run_op(4, 15, 32'h0, 4'd1); idle(PROG + 1);
        run_op(2, 0, 32'h0, 4'd4);
        idle(ERASE - 3);
        rd(16'h0, 32'h0000_C004, "R5");
        idle(3);
        rd(16'h0, 32'h0000_4004, "R5");
        rd(ARR | 16'(pa(2, 3)), 32'hFFFF_FFFF, "R5");
        run_op(5, 0, 32'h0, 4'd4); idle(ERASE + 1);
        rd(ARR | 16'(pa(4, 15)), 32'h0, "R5");

        cur_req = "R2";
        wr(16'h0, 32'h4001);
        wr(16'h10, 32'h0); wr(16'h10, 32'h556699AA); wr(16'h10, 32'hAA996655);
        wr(16'h8, 32'h8000);
        rd(16'h0, 32'h0000_6001, "R2");
        rd(ARR | 16'(pa(4, 0)), 32'hFFFF_FFFF, "R2");

        cur_req = "R10";
        nop_clear();
        rd(16'h0, 32'h0000_4000, "R10");

        cur_req = "R3";
        wr(16'h0, 32'h4001); unlock(); wr(16'h4, 32'h0);
        rd(16'h0, 32'h0000_4001, "R3");
        wr(16'h8, 32'h8000);
        rd(16'h0, 32'h0000_6001, "R3");
        nop_clear();

        cur_req = "R4";
        wr(16'h0, 32'h0001); unlock(); wr(16'h8, 32'h8000);
        rd(16'h0, 32'h0000_0001, "R4");
        rd(ARR | 16'(pa(4, 0)), 32'hFFFF_FFFF, "R4");

        cur_req = "R7";
        wr(16'h0, 32'h0004); wr(16'h8, 32'h4000);
        rd(16'h8, 32'h0000_4004, "R7");
        wr(16'h4, 32'h0004);
        rd(16'h4, 32'h0000_4000, "R7");
        wr(16'h4, 32'h4000);
        rd(16'h0, 32'h0, "R7");

        cur_req = "R8";
        lock[7] = 1'b1;
        run_op(7, 0, 32'h0, 4'd1); idle(PROG + 1);
        rd(16'h0, 32'h0000_6001, "R8");
        rd(ARR | 16'(pa(7, 0)), 32'hFFFF_FFFF, "R8");
        lock[7] = 1'b0;
        nop_clear();

        cur_req = "R9";
        run_op(9, 1, 32'h0, 4'd1);
        idle(2); lowv = 1'b1; idle(1); lowv = 1'b0;
        idle(PROG);
        rd(16'h0, 32'h0000_5001, "R9");
        rd(ARR | 16'(pa(9, 1)), 32'hFFFF_FFFF, "R9");
        nop_clear();
        rd(16'h0, 32'h0000_4000, "R10");

        cur_req = "R11";
        run_op(10, 2, 32'h1234_5678, 4'd1); idle(PROG + 1);
        run_op(10, 0, 32'h0, 4'd4);
        wr(16'h20, pa(11, 0)); wr(16'h30, 32'hDEAD_0000);
        wr(16'h0, 32'h7001); wr(16'h8, 32'h8000);
        idle(ERASE);
        rd(16'h20, pa(10, 0), "R11");
        rd(16'h30, 32'h0, "R11");
        rd(16'h0, 32'h0000_4004, "R11");
        rd(ARR | 16'(pa(10, 2)), 32'hFFFF_FFFF, "R11");

        cur_req = "R12";
        run_op(12, 0, 32'h0, 4'd2);
        rd(16'h0, 32'h0000_6002, "R12");
        nop_clear();

        cur_req = "R6";
        run_op(12, 0, 32'h0, 4'd1);
        idle(PROG - 1);
        wr(16'h4, 32'h4000);
        rd(16'h0, 32'h0000_0001, "R6");
        rd(ARR | 16'(pa(12, 0)), 32'h0, "R6");

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule